// File: doc/BRIEF.md
# CCD Clock Sequencer with Binning

This block produces the digital timing waveforms that drive a two-phase, full-frame-transfer CCD. The sensor is 1044 pixels wide and 256 rows tall by default. The block drives these outputs:

- the two vertical phases and the transfer gate;
- the two horizontal phases and the summing gate;
- the reset gate.

A single start pulse launches one frame. Two readout modes are offered:

- **Area scan:** each row is moved down by one vertical shift and then clocked out pixel by pixel.
- **Line binning:** every row of the frame is first shifted into the horizontal register with the horizontal clocks held idle. A single horizontal line then carries the summed charge out.

Each pulse width is given as a minimum time in nanoseconds. The block turns each one into a whole number of system-clock cycles, rounding up, so no minimum is ever violated. The same applies to the settling gap between the end of the last transfer-gate pulse and the first horizontal clock.

For a downstream sampler, the block emits one strobe per pixel. The strobe lands on the final cycle of the horizontal phase-2 high interval. It carries the row index, the column index and a region tag that marks the pixel as blank, bevel or effective. A busy flag covers the whole frame.

Top module: `ccd_seq_top`

## Requirements
- R1: While reset is high, and on the first cycle after it, every output is low: all clocks and gates, busy, and the pixel strobe.
- R2: A vertical shift drives `v_ph1` high for TV cycles and then `v_ph2` high for TV cycles. TV = ceil(TV_NS*CLK_MHZ/1000). The two vertical phases are never high together. `xfer_gate` is identical to `v_ph2` on every cycle.
- R3: Each pixel drives `h_ph1` high for TH cycles and then `h_ph2` high for TH cycles. TH = ceil(TH_NS*CLK_MHZ/1000). The two horizontal phases are never high together. `sum_gate` is identical to `h_ph2` on every cycle.
- R4: `rst_gate` rises on the same cycle as `h_ph1`. It stays high for RG = min(TH, ceil(TRG_NS*CLK_MHZ/1000)) cycles, and it pulses exactly once per pixel.
- R5: Between the fall of the last `xfer_gate` pulse before a line and the rise of that line's first `h_ph1`, exactly TOVR = ceil(TOVR_NS*CLK_MHZ/1000) cycles pass. All clocks are low during that gap. Horizontal and vertical clocks are never active on the same cycle.
- R6: In area-scan mode (`mode_bin`=0), each row gets exactly one vertical shift followed by a full line of COLS pixel strobes. Rows are reported in order 0..ROWS-1.
- R7: In line-binning mode (`mode_bin`=1), all ROWS vertical shifts occur before any horizontal clock. A single line of COLS strobes follows, each reporting row index 0.
- R8: `pix_valid` is high for one cycle per pixel, on the last cycle `h_ph2` is high. Within a line, `pix_col` counts 0..COLS-1.
- R9: `pix_region` is coded 2'b00 blank, 2'b01 bevel, 2'b10 effective.
  - Columns run H_BLANK blank, H_BEVEL bevel, H_EFF effective, H_BEVEL bevel, H_BLANK blank.
  - Rows run V_TOP bevel, V_EFF effective, V_BOT bevel.
  - In area scan, a blank column gives blank. Otherwise a bevel column or a bevel row gives bevel, and anything else gives effective.
  - In binning, the code depends on the column only.
- R10: `busy` rises on the cycle the first `v_ph1` pulse rises. It falls exactly one cycle after the frame's last `pix_valid`.
- R11: A start pulse that arrives while busy is ignored, together with its `mode_bin` value. The running frame completes unchanged, and no new frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock of frequency CLK_MHZ |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to read a frame |
| mode_bin | input | 1 | Readout mode sampled with start: 0 area scan, 1 line binning |
| v_ph1 | output | 1 | Vertical phase 1 |
| v_ph2 | output | 1 | Vertical phase 2 |
| xfer_gate | output | 1 | Gate between the vertical and horizontal registers, follows v_ph2 |
| h_ph1 | output | 1 | Horizontal phase 1 |
| h_ph2 | output | 1 | Horizontal phase 2 |
| sum_gate | output | 1 | Summing gate, follows h_ph2 |
| rst_gate | output | 1 | Output-node reset pulse, once per pixel |
| busy | output | 1 | High for the duration of a frame |
| pix_valid | output | 1 | One-cycle pixel strobe |
| pix_region | output | 2 | Region tag of the strobed pixel |
| pix_row | output | ROW_W | Row index of the strobed pixel |
| pix_col | output | COL_W | Column index of the strobed pixel |

## Verification
The bench hunts for these faults and how each one would show:

- **Rounding of nanosecond minimums.** It picks deliberately non-integer cycle counts. A design that rounds down would produce vertical, horizontal, reset-gate pulses or settling gaps one cycle too short.
- **Mode-dependent sequencing.** It counts vertical shifts before each line. A sequencer that confused the modes would show 1 shift where ROWS were due, or the reverse, and would mis-tag rows. A region decoder off by one at any blank/bevel/effective boundary would miscompare in the scoreboard.
- **Edges of a frame.** A start issued mid-frame with the opposite mode would restart or corrupt the frame, or append a second one. A busy flag that drops early or late would miss the one-cycle relation to the last strobe. A reset in the middle of a frame that left any clock high would show up at once.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

  typedef enum logic [1:0] {
    REG_BLANK = 2'b00,
    REG_BEVEL = 2'b01,
    REG_EFF   = 2'b10
  } region_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_V1,
    ST_V2,
    ST_OVR,
    ST_H1,
    ST_H2
  } state_t;

  // Minimum time in ns to clock cycles, rounded up, never below one cycle.
  function automatic int ns_to_cyc(int ns, int mhz);
    int c;
    c = (ns * mhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/ccd_seq_timer.sv
// Shared down-counter: loaded with (length-1) on entry to a phase,
// reports zero on the final cycle of that phase.
module ccd_seq_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] count,
  output logic         zero
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (count != '0) begin
      count <= count - 1'b1;
    end
  end

  assign zero = (count == '0);

endmodule

// File: rtl/ccd_seq_region.sv
// Maps a row/column position onto the blank / bevel / effective tag.
module ccd_seq_region import ccd_seq_pkg::*; #(
  parameter int H_BLANK = 4,
  parameter int H_BEVEL = 6,
  parameter int H_EFF   = 1024,
  parameter int V_TOP   = 2,
  parameter int V_EFF   = 250,
  parameter int COL_W   = 11,
  parameter int ROW_W   = 8
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic             bin,
  output region_t          region
);

  localparam logic [COL_W-1:0] C_BEV_LO = COL_W'(H_BLANK);
  localparam logic [COL_W-1:0] C_EFF_LO = COL_W'(H_BLANK + H_BEVEL);
  localparam logic [COL_W-1:0] C_BEV_HI = COL_W'(H_BLANK + H_BEVEL + H_EFF);
  localparam logic [COL_W-1:0] C_BLK_HI = COL_W'(H_BLANK + 2 * H_BEVEL + H_EFF);
  localparam logic [ROW_W-1:0] R_EFF_LO = ROW_W'(V_TOP);
  localparam logic [ROW_W-1:0] R_BEV_HI = ROW_W'(V_TOP + V_EFF);

  logic col_blank, col_bevel, row_bevel;

  always_comb begin
    col_blank = (col < C_BEV_LO) || (col >= C_BLK_HI);
    col_bevel = (col < C_EFF_LO) || (col >= C_BEV_HI);
    row_bevel = !bin && ((row < R_EFF_LO) || (row >= R_BEV_HI));
    if (col_blank)                   region = REG_BLANK;
    else if (col_bevel || row_bevel) region = REG_BEVEL;
    else                             region = REG_EFF;
  end

endmodule

// File: rtl/ccd_seq_ctrl.sv
// Frame sequencer: vertical shift phases, settling gap, per-pixel
// horizontal phases, row/column bookkeeping for both readout modes.
module ccd_seq_ctrl import ccd_seq_pkg::*; #(
  parameter int COLS   = 1044,
  parameter int ROWS   = 256,
  parameter int COL_W  = 11,
  parameter int ROW_W  = 8,
  parameter int TMR_W  = 12,
  parameter int TV_C   = 2200,
  parameter int TH_C   = 10,
  parameter int TOVR_C = 600
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_bin,
  input  logic             tmr_zero,
  output state_t           state,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col,
  output logic             bin_q,
  output logic             tmr_load,
  output logic [TMR_W-1:0] tmr_val
);

  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
  localparam logic [TMR_W-1:0] TV_L     = TMR_W'(TV_C - 1);
  localparam logic [TMR_W-1:0] TH_L     = TMR_W'(TH_C - 1);
  localparam logic [TMR_W-1:0] TOVR_L   = TMR_W'(TOVR_C - 1);

  state_t nxt;
  logic   row_last, col_last;

  assign row_last = (row == ROW_LAST);
  assign col_last = (col == COL_LAST);

  always_comb begin
    nxt      = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state)
      ST_IDLE: if (start) begin
        nxt = ST_V1; tmr_load = 1'b1; tmr_val = TV_L;
      end
      ST_V1: if (tmr_zero) begin
        nxt = ST_V2; tmr_load = 1'b1; tmr_val = TV_L;
      end
      ST_V2: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (bin_q && !row_last) begin
          nxt = ST_V1; tmr_val = TV_L;
        end else begin
          nxt = ST_OVR; tmr_val = TOVR_L;
        end
      end
      ST_OVR: if (tmr_zero) begin
        nxt = ST_H1; tmr_load = 1'b1; tmr_val = TH_L;
      end
      ST_H1: if (tmr_zero) begin
        nxt = ST_H2; tmr_load = 1'b1; tmr_val = TH_L;
      end
      ST_H2: if (tmr_zero) begin
        if (!col_last) begin
          nxt = ST_H1; tmr_load = 1'b1; tmr_val = TH_L;
        end else if (!bin_q && !row_last) begin
          nxt = ST_V1; tmr_load = 1'b1; tmr_val = TV_L;
        end else begin
          nxt = ST_IDLE;
        end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      row   <= '0;
      col   <= '0;
      bin_q <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_IDLE && start) begin
        row   <= '0;
        col   <= '0;
        bin_q <= mode_bin;
      end
      if (state == ST_V2 && tmr_zero && bin_q) begin
        // binned line is reported as row 0
        row <= row_last ? '0 : row + 1'b1;
      end
      if (state == ST_H2 && tmr_zero) begin
        if (!col_last) begin
          col <= col + 1'b1;
        end else begin
          col <= '0;
          if (!bin_q && !row_last) row <= row + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/ccd_seq_top.sv
module ccd_seq_top import ccd_seq_pkg::*; #(
  parameter int H_BLANK = 4,
  parameter int H_BEVEL = 6,
  parameter int H_EFF   = 1024,
  parameter int V_TOP   = 2,
  parameter int V_EFF   = 250,
  parameter int V_BOT   = 4,
  parameter int CLK_MHZ = 200,
  parameter int TV_NS   = 11000,
  parameter int TH_NS   = 50,
  parameter int TRG_NS  = 15,
  parameter int TOVR_NS = 3000,
  localparam int COLS   = 2 * H_BLANK + 2 * H_BEVEL + H_EFF,
  localparam int ROWS   = V_TOP + V_EFF + V_BOT,
  localparam int COL_W  = (COLS > 1) ? $clog2(COLS) : 1,
  localparam int ROW_W  = (ROWS > 1) ? $clog2(ROWS) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_bin,
  output logic             v_ph1,
  output logic             v_ph2,
  output logic             xfer_gate,
  output logic             h_ph1,
  output logic             h_ph2,
  output logic             sum_gate,
  output logic             rst_gate,
  output logic             busy,
  output logic             pix_valid,
  output logic [1:0]       pix_region,
  output logic [ROW_W-1:0] pix_row,
  output logic [COL_W-1:0] pix_col
);

  localparam int TV_C   = ns_to_cyc(TV_NS, CLK_MHZ);
  localparam int TH_C   = ns_to_cyc(TH_NS, CLK_MHZ);
  localparam int RG_RAW = ns_to_cyc(TRG_NS, CLK_MHZ);
  localparam int RG_C   = (RG_RAW > TH_C) ? TH_C : RG_RAW;
  localparam int TOVR_C = ns_to_cyc(TOVR_NS, CLK_MHZ);
  localparam int TMAX   = imax(imax(TV_C, TH_C), TOVR_C);
  localparam int TMR_W  = $clog2(TMAX + 1);
  localparam logic [TMR_W-1:0] RG_TH = TMR_W'(TH_C - RG_C);

  state_t           st;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             bin_q;
  logic             tmr_load, tmr_zero;
  logic [TMR_W-1:0] tmr_val, tmr_cnt;
  region_t          reg_c;

  ccd_seq_timer #(.W(TMR_W)) u_tmr (
    .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
    .count(tmr_cnt), .zero(tmr_zero)
  );

  ccd_seq_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .COL_W(COL_W), .ROW_W(ROW_W), .TMR_W(TMR_W),
    .TV_C(TV_C), .TH_C(TH_C), .TOVR_C(TOVR_C)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_bin(mode_bin),
    .tmr_zero(tmr_zero), .state(st), .row(row), .col(col), .bin_q(bin_q),
    .tmr_load(tmr_load), .tmr_val(tmr_val)
  );

  ccd_seq_region #(
    .H_BLANK(H_BLANK), .H_BEVEL(H_BEVEL), .H_EFF(H_EFF),
    .V_TOP(V_TOP), .V_EFF(V_EFF), .COL_W(COL_W), .ROW_W(ROW_W)
  ) u_region (
    .col(col), .row(row), .bin(bin_q), .region(reg_c)
  );

  // Registered output stage: every output lags the state by one cycle,
  // so all waveforms stay aligned and glitch-free.
  always_ff @(posedge clk) begin
    if (rst) begin
      v_ph1      <= 1'b0;
      v_ph2      <= 1'b0;
      xfer_gate  <= 1'b0;
      h_ph1      <= 1'b0;
      h_ph2      <= 1'b0;
      sum_gate   <= 1'b0;
      rst_gate   <= 1'b0;
      busy       <= 1'b0;
      pix_valid  <= 1'b0;
      pix_region <= 2'b00;
      pix_row    <= '0;
      pix_col    <= '0;
    end else begin
      v_ph1      <= (st == ST_V1);
      v_ph2      <= (st == ST_V2);
      xfer_gate  <= (st == ST_V2);
      h_ph1      <= (st == ST_H1);
      h_ph2      <= (st == ST_H2);
      sum_gate   <= (st == ST_H2);
      rst_gate   <= (st == ST_H1) && (tmr_cnt >= RG_TH);
      busy       <= (st != ST_IDLE);
      pix_valid  <= (st == ST_H2) && tmr_zero;
      pix_region <= reg_c;
      pix_row    <= row;
      pix_col    <= col;
    end
  end

endmodule

// File: rtl/ccd_seq_chk.sv
module ccd_seq_chk (
  input logic clk,
  input logic rst,
  input logic v_ph1,
  input logic v_ph2,
  input logic xfer_gate,
  input logic h_ph1,
  input logic h_ph2,
  input logic sum_gate,
  input logic rst_gate,
  input logic busy,
  input logic pix_valid
);

  // R2
  v_phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(v_ph1 && v_ph2));

  // R2
  xfer_follow_chk: assert property (@(posedge clk) disable iff (rst)
    xfer_gate == v_ph2);

  // R3
  h_phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(h_ph1 && h_ph2));

  // R3
  sum_follow_chk: assert property (@(posedge clk) disable iff (rst)
    sum_gate == h_ph2);

  // R4
  rst_gate_in_ph1_chk: assert property (@(posedge clk) disable iff (rst)
    rst_gate |-> h_ph1);

  // R5
  hv_disjoint_chk: assert property (@(posedge clk) disable iff (rst)
    (h_ph1 || h_ph2) |-> !(v_ph1 || v_ph2));

  // R8
  strobe_in_ph2_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> h_ph2);

  // R8
  strobe_ends_ph2_chk: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !h_ph2);

  // R10
  busy_cover_chk: assert property (@(posedge clk) disable iff (rst)
    (v_ph1 || v_ph2 || h_ph1 || h_ph2 || pix_valid) |-> busy);

endmodule

bind ccd_seq_top ccd_seq_chk u_chk (
  .clk(clk), .rst(rst), .v_ph1(v_ph1), .v_ph2(v_ph2), .xfer_gate(xfer_gate),
  .h_ph1(h_ph1), .h_ph2(h_ph2), .sum_gate(sum_gate), .rst_gate(rst_gate),
  .busy(busy), .pix_valid(pix_valid)
);

// File: tb/tb_ccd_seq_top.sv
`timescale 1ns/1ps
module tb_ccd_seq_top;

  // small geometry, awkward ns values to exercise round-up
  localparam int HB = 1, HV = 2, HE = 4, VT = 1, VE = 3, VB = 1;
  localparam int COLS = 2*HB + 2*HV + HE;   // 10
  localparam int ROWS = VT + VE + VB;       // 5
  localparam int TV = 8;    // 37 ns * 200 MHz = 7.4 -> 8
  localparam int TH = 3;    // 11 ns -> 2.2 -> 3
  localparam int RG = 1;    // 4 ns -> 0.8 -> 1
  localparam int TOVR = 4;  // 19 ns -> 3.8 -> 4

  logic clk = 0, rst = 1, start = 0, mode_bin = 0;
  logic v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, rst_gate, busy, pix_valid;
  logic [1:0] pix_region;
  logic [2:0] pix_row;
  logic [3:0] pix_col;

  always #2.5 clk = ~clk;

  ccd_seq_top #(
    .H_BLANK(HB), .H_BEVEL(HV), .H_EFF(HE), .V_TOP(VT), .V_EFF(VE), .V_BOT(VB),
    .CLK_MHZ(200), .TV_NS(37), .TH_NS(11), .TRG_NS(4), .TOVR_NS(19)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .mode_bin(mode_bin),
    .v_ph1(v_ph1), .v_ph2(v_ph2), .xfer_gate(xfer_gate), .h_ph1(h_ph1),
    .h_ph2(h_ph2), .sum_gate(sum_gate), .rst_gate(rst_gate), .busy(busy),
    .pix_valid(pix_valid), .pix_region(pix_region), .pix_row(pix_row),
    .pix_col(pix_col)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  typedef struct { int row; int col; int rg; } pix_t;
  pix_t sb[$];
  bit exp_bin = 0;

  // R9 expected region from the stated layout
  function automatic int exp_region(int r, int c, bit bin);
    bit cblank, cbev, rbev;
    cblank = (c < HB) || (c >= COLS - HB);
    cbev   = (c < HB + HV) || (c >= HB + HV + HE);
    rbev   = !bin && ((r < VT) || (r >= VT + VE));
    if (cblank) return 0;
    if (cbev || rbev) return 1;
    return 2;
  endfunction

  task automatic push_frame(bit bin);
    pix_t p;
    int nrows = bin ? 1 : ROWS;
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++) begin
        p.row = r; p.col = c; p.rg = exp_region(r, c, bin);
        sb.push_back(p);
      end
  endtask

  // ---------------- monitor ----------------
  int cyc = 0, last_strobe = -10;
  int run_v1, run_v2, run_h1, run_h2, run_rg;
  bit pv1, pv2, ph1, ph2, prg, pbusy;
  int gap, vcnt, rg_cnt;
  bit gap_on;
  int tg_mis = 0, sg_mis = 0, vboth = 0, hboth = 0;

  always @(negedge clk) begin
    pix_t e;
    cyc++;
    if (rst) begin
      run_v1 = 0; run_v2 = 0; run_h1 = 0; run_h2 = 0; run_rg = 0;
      pv1 = 0; pv2 = 0; ph1 = 0; ph2 = 0; prg = 0; pbusy = 0;
      gap = 0; gap_on = 0; vcnt = 0; rg_cnt = 0;
    end else begin
      if (xfer_gate !== v_ph2) tg_mis++;
      if (sum_gate !== h_ph2) sg_mis++;
      if (v_ph1 && v_ph2) vboth++;
      if (h_ph1 && h_ph2) hboth++;
      if (pv1 && !v_ph1) chk(run_v1 == TV, "R2 v_ph1 width", run_v1, TV);
      if (pv2 && !v_ph2) begin
        chk(run_v2 == TV, "R2 v_ph2 width", run_v2, TV);
        vcnt++; gap = 1; gap_on = 1;
      end else if (gap_on && !h_ph1 && !v_ph1) gap++;
      if (!pv1 && v_ph1) gap_on = 0;
      if (ph1 && !h_ph1) chk(run_h1 == TH, "R3 h_ph1 width", run_h1, TH);
      if (ph2 && !h_ph2) chk(run_h2 == TH, "R3 h_ph2 width", run_h2, TH);
      if (prg && !rst_gate) chk(run_rg == RG, "R4 rst_gate width", run_rg, RG);
      if (!ph1 && h_ph1 && gap_on) begin
        chk(gap == TOVR, "R5 settling gap", gap, TOVR);
        if (exp_bin) chk(vcnt == ROWS, "R7 shifts before line", vcnt, ROWS);
        else         chk(vcnt == 1, "R6 shifts before line", vcnt, 1);
        vcnt = 0; gap_on = 0;
      end
      if (!prg && rst_gate) begin
        chk(h_ph1 && !ph1, "R4 rst_gate aligned to h_ph1 rise", int'(h_ph1), 1);
        rg_cnt++;
      end
      if (pix_valid) begin
        chk(h_ph2, "R8 strobe inside h_ph2", int'(h_ph2), 1);
        chk(rg_cnt == 1, "R4 one reset pulse per pixel", rg_cnt, 1);
        rg_cnt = 0;
        last_strobe = cyc;
        if (sb.size() == 0) chk(0, "R11 unexpected strobe", int'(pix_col), -1);
        else begin
          e = sb.pop_front();
          chk(int'(pix_col) == e.col, "R8 column index", int'(pix_col), e.col);
          chk(int'(pix_row) == e.row, exp_bin ? "R7 row index" : "R6 row index",
              int'(pix_row), e.row);
          chk(int'(pix_region) == e.rg, "R9 region code", int'(pix_region), e.rg);
        end
      end
      if (pbusy && !busy) chk(cyc == last_strobe + 1, "R10 busy fall", cyc, last_strobe + 1);
      if (!pbusy && busy) chk(v_ph1 && !pv1, "R10 busy rise with v_ph1", int'(v_ph1), 1);
      run_v1 = v_ph1 ? run_v1 + 1 : 0;
      run_v2 = v_ph2 ? run_v2 + 1 : 0;
      run_h1 = h_ph1 ? run_h1 + 1 : 0;
      run_h2 = h_ph2 ? run_h2 + 1 : 0;
      run_rg = rst_gate ? run_rg + 1 : 0;
      pv1 = v_ph1; pv2 = v_ph2; ph1 = h_ph1; ph2 = h_ph2; prg = rst_gate; pbusy = busy;
    end
  end

  // ---------------- driver ----------------
  task automatic pulse_start(bit m);
    @(negedge clk); start = 1; mode_bin = m;
    @(negedge clk); start = 0; mode_bin = 0;
  endtask

  task automatic wait_idle();
    int n = 0;
    repeat (3) @(negedge clk);
    while (busy && n < 20000) begin @(negedge clk); n++; end
    chk(!busy, "R10 frame completes", int'(busy), 0);
  endtask

  task automatic check_quiet(string req);
    chk({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, rst_gate, busy, pix_valid} == 9'b0,
        req, int'({v_ph1, v_ph2, xfer_gate, h_ph1, h_ph2, sum_gate, rst_gate, busy, pix_valid}), 0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  task automatic run_frame(bit bin);
    exp_bin = bin;
    push_frame(bin);
    pulse_start(bin);
    repeat (20) @(negedge clk);
    pulse_start(!bin);              // R11 ignored while busy
    wait_idle();
    chk(sb.size() == 0, bin ? "R7 all pixels emitted" : "R6 all pixels emitted", sb.size(), 0);
    repeat (40) @(negedge clk);
    check_quiet("R11 no extra frame after ignored start");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_quiet("R1 outputs during reset");
    rst = 0;
    @(negedge clk);
    check_quiet("R1 outputs after reset");

    run_frame(0);
    run_frame(1);

    // reset in the middle of an area frame
    exp_bin = 0;
    push_frame(0);
    pulse_start(0);
    repeat (150) @(negedge clk);
    rst = 1;
    @(negedge clk);
    check_quiet("R1 mid-frame reset");
    sb.delete();
    rst = 0;
    @(negedge clk);
    check_quiet("R1 idle after mid-frame reset");

    run_frame(1);
    run_frame(0);

    chk(tg_mis == 0, "R2 xfer_gate equals v_ph2", tg_mis, 0);
    chk(vboth == 0, "R2 vertical phases exclusive", vboth, 0);
    chk(sg_mis == 0, "R3 sum_gate equals h_ph2", sg_mis, 0);
    chk(hboth == 0, "R3 horizontal phases exclusive", hboth, 0);
    summary();
    $finish;
  end

  initial begin
    #900000;
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

endmodule